// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into characters. It watches a resynchronized copy of the line for a high-to-low transition and confirms the start bit at mid-bit on a 16x oversampling tick. It then takes one sample from the middle of each data bit, one from the optional parity bit and one from a single stop bit. Character width runs from five to nine bits, and parity may be off, even or odd. These settings arrive on two small configuration inputs shared with the matching transmitter.

Each finished character sits in a one-character holding register, together with its own parity and framing error flags. A downstream agent reads it with a single-cycle strobe. A character of up to eight bits takes one read. A nine-bit character takes two reads, and the size code chooses whether the low byte or the high byte comes first. The complete flag and both error flags drop after the last read of the character. The baud-rate tick comes from outside.

Top module: `serial_frame_rx`

## Requirements
- R1: Size code `cfg_size_i` selects the data width: 0→5, 1→6, 2→7, 3→8 bits, 6 or 7→9 bits, and the unused codes 4 and 5 behave as 8 bits. Data bits arrive LSB first.
- R2: Reception starts on a falling edge of the synchronized line. If the line is high again when the start bit is rechecked on the 8th tick after the edge, the attempt is dropped and no character or flag appears.
- R3: Every data, parity and stop bit is sampled once, 16 ticks after the previous sample, which is mid-bit.
- R4: When `cfg_par_i` is 2 (even) or 3 (odd), a parity bit follows the data. `perr_o` is set with the character when that bit does not give the selected parity over the data bits.
- R5: When `cfg_par_i` is 0, or the unused code 1, no parity bit is expected and `perr_o` stays low.
- R6: Exactly one stop bit is expected. `done_o` rises within that stop bit's period, before a second stop bit could end.
- R7: A stop bit sampled low sets `ferr_o`, and the character is still delivered.
- R8: `done_o` rises after the stop-bit sample. `perr_o` and `ferr_o` are only high while `done_o` is high.
- R9: For 5 to 8 bit characters, `rd_data_o` shows the data zero-extended to 8 bits. One `rd_i` pulse clears `done_o`, `perr_o` and `ferr_o`.
- R10: For 9-bit characters, two reads are needed. Code 6 gives the low byte first and code 7 gives the high byte first. The high byte is `{7'b0, bit8}`. The flags clear after the second read.
- R11: `rd_i` while `done_o` is low has no effect, and `rd_data_o` reads zero while `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size_i | input | 3 | Character size code |
| cfg_par_i | input | 2 | Parity mode code |
| tick16_i | input | 1 | One-cycle pulse, 16 per bit period |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| rd_i | input | 1 | Read strobe for one byte |
| rd_data_o | output | 8 | Byte currently presented for reading |
| done_o | output | 1 | A received character is waiting |
| perr_o | output | 1 | Parity error of the waiting character |
| ferr_o | output | 1 | Framing error of the waiting character |

## Verification
The hardest states to reach are an aborted start and a nine-bit character read in the high-first order. Both need exact timing or configuration on the serial line, so random bytes seldom produce them. Directed frames cover them: a low pulse far shorter than half a bit, and nine-bit frames with bit 8 set under both size codes. Seeded random frames then mix every size code, every parity code, injected wrong parity bits and low stop bits. Each of these frames is checked against bytes and flags that bench functions compute.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

   // data bit count for a size code; unused codes fall back to eight
   function automatic logic [3:0] size_to_bits(input logic [2:0] code);
      case (code)
         3'd0:    size_to_bits = 4'd5;
         3'd1:    size_to_bits = 4'd6;
         3'd2:    size_to_bits = 4'd7;
         3'd6,
         3'd7:    size_to_bits = 4'd9;
         default: size_to_bits = 4'd8;
      endcase
   endfunction

   function automatic logic size_is_nine(input logic [2:0] code);
      size_is_nine = (code[2:1] == 2'b11);
   endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic fall_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rx_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= d_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[i] <= 1'b1;
               else        chain_q[i] <= chain_q[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= chain_q[STAGES-1];

   assign q_o    = chain_q[STAGES-1];
   assign fall_o = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
   import serial_rx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       line_i,
   input  logic       fall_i,
   input  logic [2:0] cfg_size_i,
   input  logic [1:0] cfg_par_i,
   output logic       frame_v_o,
   output logic [8:0] frame_dat_o,
   output logic       frame_perr_o,
   output logic       frame_ferr_o,
   output logic       frame_nine_o,
   output logic       frame_hifirst_o
);
   localparam int CW   = $clog2(OSR);
   localparam int HALF = OSR / 2;

   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad
         $error("rx_bit_engine: OSR must be even and at least 4");
      end
   endgenerate

   rx_state_e      st_q;
   logic [CW-1:0]  cnt_q;
   logic [3:0]     bit_q;
   logic [3:0]     nbits_q;
   logic [8:0]     sh_q;
   logic           pen_q, podd_q, nine_q, hif_q;
   logic           perr_q, ferr_q, fv_q;
   logic           exp_par;

   assign exp_par = (^sh_q) ^ podd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RX_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         nbits_q <= 4'd8;
         sh_q    <= '0;
         pen_q   <= 1'b0;
         podd_q  <= 1'b0;
         nine_q  <= 1'b0;
         hif_q   <= 1'b0;
         perr_q  <= 1'b0;
         ferr_q  <= 1'b0;
         fv_q    <= 1'b0;
      end else begin
         fv_q <= 1'b0;
         case (st_q)
            RX_IDLE: begin
               if (fall_i) begin
                  st_q  <= RX_START;
                  cnt_q <= '0;
               end
            end
            RX_START: begin
               if (tick_i) begin
                  if (cnt_q == CW'(HALF - 1)) begin
                     cnt_q <= '0;
                     if (!line_i) begin
                        st_q    <= RX_DATA;
                        bit_q   <= '0;
                        sh_q    <= '0;
                        perr_q  <= 1'b0;
                        nbits_q <= size_to_bits(cfg_size_i);
                        nine_q  <= size_is_nine(cfg_size_i);
                        hif_q   <= cfg_size_i[0];
                        pen_q   <= cfg_par_i[1];
                        podd_q  <= cfg_par_i[0];
                     end else begin
                        st_q <= RX_IDLE;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               if (tick_i) begin
                  if (cnt_q == CW'(OSR - 1)) begin
                     cnt_q <= '0;
                     if (st_q == RX_DATA) begin
                        sh_q[bit_q] <= line_i;
                        bit_q       <= bit_q + 1'b1;
                        if (bit_q == nbits_q - 1'b1)
                           st_q <= pen_q ? RX_PAR : RX_STOP;
                     end else if (st_q == RX_PAR) begin
                        perr_q <= (line_i != exp_par);
                        st_q   <= RX_STOP;
                     end else begin
                        ferr_q <= ~line_i;
                        fv_q   <= 1'b1;
                        st_q   <= RX_IDLE;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign frame_v_o       = fv_q;
   assign frame_dat_o     = sh_q;
   assign frame_perr_o    = perr_q;
   assign frame_ferr_o    = ferr_q;
   assign frame_nine_o    = nine_q;
   assign frame_hifirst_o = hif_q;
endmodule

// File: rtl/rx_char_hold.sv
module rx_char_hold (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_v_i,
   input  logic [8:0] frame_dat_i,
   input  logic       frame_perr_i,
   input  logic       frame_ferr_i,
   input  logic       frame_nine_i,
   input  logic       frame_hifirst_i,
   input  logic       rd_i,
   output logic [7:0] rd_data_o,
   output logic       done_o,
   output logic       perr_o,
   output logic       ferr_o
);
   logic [8:0] dat_q;
   logic       done_q, perr_q, ferr_q, nine_q, hif_q, phase_q;
   logic [7:0] lo_b, hi_b, first_b, second_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q   <= '0;
         done_q  <= 1'b0;
         perr_q  <= 1'b0;
         ferr_q  <= 1'b0;
         nine_q  <= 1'b0;
         hif_q   <= 1'b0;
         phase_q <= 1'b0;
      end else if (frame_v_i) begin
         dat_q   <= frame_dat_i;
         done_q  <= 1'b1;
         perr_q  <= frame_perr_i;
         ferr_q  <= frame_ferr_i;
         nine_q  <= frame_nine_i;
         hif_q   <= frame_hifirst_i;
         phase_q <= 1'b0;
      end else if (rd_i && done_q) begin
         if (nine_q && !phase_q) begin
            phase_q <= 1'b1;
         end else begin
            done_q  <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            phase_q <= 1'b0;
         end
      end
   end

   always_comb begin
      lo_b     = dat_q[7:0];
      hi_b     = {7'b0, dat_q[8]};
      first_b  = hif_q ? hi_b : lo_b;
      second_b = hif_q ? lo_b : hi_b;
      if (!done_q)      rd_data_o = 8'h00;
      else if (!nine_q) rd_data_o = lo_b;
      else              rd_data_o = phase_q ? second_b : first_b;
   end

   assign done_o = done_q;
   assign perr_o = perr_q;
   assign ferr_o = ferr_q;
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] cfg_size_i,
   input  logic [1:0] cfg_par_i,
   input  logic       tick16_i,
   input  logic       rxd_i,
   input  logic       rd_i,
   output logic [7:0] rd_data_o,
   output logic       done_o,
   output logic       perr_o,
   output logic       ferr_o
);
   logic       line_s, line_fall;
   logic       frame_v;
   logic [8:0] frame_dat;
   logic       frame_perr, frame_ferr, frame_nine, frame_hif;

   rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (rxd_i),
      .q_o    (line_s),
      .fall_o (line_fall)
   );

   rx_bit_engine #(.OSR(OSR)) u_eng (
      .clk             (clk),
      .rst_n           (rst_n),
      .tick_i          (tick16_i),
      .line_i          (line_s),
      .fall_i          (line_fall),
      .cfg_size_i      (cfg_size_i),
      .cfg_par_i       (cfg_par_i),
      .frame_v_o       (frame_v),
      .frame_dat_o     (frame_dat),
      .frame_perr_o    (frame_perr),
      .frame_ferr_o    (frame_ferr),
      .frame_nine_o    (frame_nine),
      .frame_hifirst_o (frame_hif)
   );

   rx_char_hold u_hold (
      .clk             (clk),
      .rst_n           (rst_n),
      .frame_v_i       (frame_v),
      .frame_dat_i     (frame_dat),
      .frame_perr_i    (frame_perr),
      .frame_ferr_i    (frame_ferr),
      .frame_nine_i    (frame_nine),
      .frame_hifirst_i (frame_hif),
      .rd_i            (rd_i),
      .rd_data_o       (rd_data_o),
      .done_o          (done_o),
      .perr_o          (perr_o),
      .ferr_o          (ferr_o)
   );
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick16_i,
   input logic       rd_i,
   input logic       done_o,
   input logic       perr_o,
   input logic       ferr_o,
   input logic [7:0] rd_data_o,
   input logic       frame_v
);
   // error flags belong to a waiting character
   assert_err_with_char_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_o || ferr_o) |-> done_o);

   // the complete flag only drops after a read strobe
   assert_clear_by_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_o) |-> $past(rd_i));

   // the complete flag only rises after a finished frame
   assert_set_by_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(frame_v));

   // the stop sample that ends a frame is taken on a tick
   assert_sample_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_v |-> $past(tick16_i));

   // nothing to read when nothing waits
   assert_zero_when_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (rd_data_o == 8'h00));
endmodule

bind serial_frame_rx serial_frame_rx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick16_i  (tick16_i),
   .rd_i      (rd_i),
   .done_o    (done_o),
   .perr_o    (perr_o),
   .ferr_o    (ferr_o),
   .rd_data_o (rd_data_o),
   .frame_v   (frame_v)
);

// File: tb/sim_serial_frame_rx.sv
`timescale 1ns/1ps
module sim_serial_frame_rx;
   localparam int TDIV = 3;
   localparam int BITC = 16 * TDIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_size_i = 3'd3;
   logic [1:0] cfg_par_i = 2'd0;
   logic       tick16_i = 1'b0;
   logic       rxd_i = 1'b1;
   logic       rd_i = 1'b0;
   logic [7:0] rd_data_o;
   logic       done_o, perr_o, ferr_o;
   int         checks = 0;
   int         errors = 0;

   always #2 clk = ~clk;

   serial_frame_rx u0 (
      .clk(clk), .rst_n(rst_n), .cfg_size_i(cfg_size_i), .cfg_par_i(cfg_par_i),
      .tick16_i(tick16_i), .rxd_i(rxd_i), .rd_i(rd_i), .rd_data_o(rd_data_o),
      .done_o(done_o), .perr_o(perr_o), .ferr_o(ferr_o)
   );

   initial begin
      forever begin
         for (int k = 0; k < TDIV; k++) begin
            @(negedge clk);
            tick16_i = (k == 0);
         end
      end
   end

   function automatic int nbits_of(input logic [2:0] c);
      case (c)
         3'd0: return 5;
         3'd1: return 6;
         3'd2: return 7;
         3'd6, 3'd7: return 9;
         default: return 8;
      endcase
   endfunction

   function automatic logic [8:0] masked(input logic [8:0] d, input logic [2:0] c);
      return d & 9'((1 << nbits_of(c)) - 1);
   endfunction

   function automatic logic par_bit(input logic [8:0] d, input logic [2:0] c, input logic odd);
      return (^masked(d, c)) ^ odd;
   endfunction

   function automatic logic [7:0] exp_byte(input logic [8:0] d, input logic [2:0] c, input int idx);
      logic [8:0] m;
      logic       hi;
      m  = masked(d, c);
      hi = (nbits_of(c) == 9) && ((idx == 0) == c[0]);
      return hi ? {7'b0, m[8]} : m[7:0];
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic line_bit(input logic v);
      rxd_i = v;
      repeat (BITC) @(negedge clk);
   endtask

   task automatic send(input logic [8:0] d, input logic [2:0] c, input logic [1:0] p,
                       input logic bad_par, input logic stop_v);
      cfg_size_i = c;
      cfg_par_i  = p;
      line_bit(1'b0);
      for (int i = 0; i < nbits_of(c); i++) line_bit(d[i]);
      if (p[1]) line_bit(par_bit(d, c, p[0]) ^ bad_par);
      line_bit(stop_v);
      rxd_i = 1'b1;
   endtask

   task automatic frame_and_check(input logic [8:0] d, input logic [2:0] c, input logic [1:0] p,
                                  input logic bad_par, input logic stop_v);
      int n;
      send(d, c, p, bad_par, stop_v);
      // done must be up by the end of the single stop bit
      chk("R6 R8 done after one stop bit", done_o, 1);
      chk(p[1] ? "R4 parity flag" : "R5 parity off", perr_o, p[1] & bad_par);
      chk("R7 framing flag", ferr_o, !stop_v);
      n = (nbits_of(c) == 9) ? 2 : 1;
      for (int r = 0; r < n; r++) begin
         chk((n == 2) ? "R10 nine-bit byte order" : "R1 R9 data byte",
             rd_data_o, exp_byte(d, c, r));
         if (r == 0 && n == 2) chk("R10 still waiting after first read", done_o, 1);
         rd_i = 1'b1;
         @(negedge clk);
         rd_i = 1'b0;
         if (r == 0 && n == 2) chk("R10 flag held between reads", done_o, 1);
      end
      chk("R9 R10 done cleared by final read", done_o, 0);
      chk("R9 R10 perr cleared", perr_o, 0);
      chk("R9 R10 ferr cleared", ferr_o, 0);
      line_bit(1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [2:0] sizes [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6, 3'd7};
      logic [8:0] d;
      void'($urandom(32'h5eed_0017));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 reset done", done_o, 0);
      chk("R8 reset perr", perr_o, 0);
      chk("R8 reset ferr", ferr_o, 0);
      chk("R11 reset data", rd_data_o, 0);
      line_bit(1'b1);

      // R11: stray read while empty
      rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
      chk("R11 stray read ignored", done_o, 0);
      chk("R11 stray read data", rd_data_o, 0);

      // R1: every size code, including the unused ones
      frame_and_check(9'h1b5, 3'd0, 2'd0, 1'b0, 1'b1);
      frame_and_check(9'h1b5, 3'd1, 2'd0, 1'b0, 1'b1);
      frame_and_check(9'h1b5, 3'd2, 2'd0, 1'b0, 1'b1);
      frame_and_check(9'h0a5, 3'd3, 2'd0, 1'b0, 1'b1);
      frame_and_check(9'h1c3, 3'd4, 2'd0, 1'b0, 1'b1);
      frame_and_check(9'h13c, 3'd5, 2'd0, 1'b0, 1'b1);
      // R10: both byte orders with the ninth bit set
      frame_and_check(9'h15a, 3'd6, 2'd0, 1'b0, 1'b1);
      frame_and_check(9'h15a, 3'd7, 2'd0, 1'b0, 1'b1);
      frame_and_check(9'h0ff, 3'd7, 2'd3, 1'b0, 1'b1);
      // R4 / R5 parity cases
      frame_and_check(9'h033, 3'd3, 2'd2, 1'b1, 1'b1);
      frame_and_check(9'h031, 3'd3, 2'd3, 1'b1, 1'b1);
      frame_and_check(9'h031, 3'd3, 2'd3, 1'b0, 1'b1);
      frame_and_check(9'h07e, 3'd3, 2'd1, 1'b0, 1'b1);
      // R7 low stop bit
      frame_and_check(9'h044, 3'd2, 2'd2, 1'b0, 1'b0);

      // R2: short low glitch must not start a character
      rxd_i = 1'b0;
      repeat (9) @(negedge clk);
      rxd_i = 1'b1;
      repeat (3 * BITC) @(negedge clk);
      chk("R2 glitch rejected", done_o, 0);
      chk("R2 glitch no flags", perr_o | ferr_o, 0);
      frame_and_check(9'h0c9, 3'd3, 2'd2, 1'b0, 1'b1);

      // R3 and mixed coverage: seeded random frames
      for (int f = 0; f < 60; f++) begin
         d = 9'($urandom);
         frame_and_check(d, sizes[$urandom % 6], 2'($urandom),
                         ($urandom % 8) == 0, ($urandom % 8) != 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule